// File: doc/BRIEF.md
# Vector lane workload splitter

This block takes one vector operation request and works out what each lane of a multi-lane vector unit has to do with it. The request carries a first active element index, an active length and an element width. Elements are interleaved across the lanes: element `i` belongs to lane `i mod LANES` and sits at local position `i / LANES` inside that lane. For each lane the block produces the local position of the first element the lane must process, how many elements it processes, and an idle flag.

The tricky case is a nonzero start index that does not divide evenly by the lane count. Lanes whose id is below the remainder of the start index have already passed one more of their own elements, so their local start is one higher than the other lanes. Local end positions are uneven in the same way, through the remainder of the length. Every difference is clamped so that no lane's start or count can wrap around to a huge value. A request whose start index is not below its length, or whose length exceeds the maximum for its element width, gives no work to any lane.

Requests enter through a valid/ready handshake. The per-lane results are registered and held until the consumer takes them, and only then is another request accepted.

Top module: `vls_top`

## Requirements
- R1: For a legal request, each lane's count equals the number of element indices i with start <= i < length and i mod LANES equal to the lane id.
- R2: For a lane with nonzero count, the start output equals (first such owned index) / LANES, that is start/LANES plus one when the lane id is below start mod LANES.
- R3: No lane's count exceeds VLEN/LANES, and no lane's start or count ever shows a wrapped (all-ones) value.
- R4: A request whose start index is greater than or equal to its length makes every lane idle with count 0 and start 0.
- R5: The element width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) sets the maximum length to VLEN >> code; a request whose length exceeds it makes every lane idle with count 0 and start 0.
- R6: A lane's idle flag is high exactly when its count is 0, and an idle lane's start output is 0.
- R7: `out_valid` rises in the cycle after a request handshake; `req_ready` is low whenever `out_valid` is high and high otherwise.
- R8: While `out_valid` is high and `out_ready` is low, all outputs hold their values; `out_valid` falls in the cycle after it is high together with `out_ready`.
- R9: For a legal request, the counts of all lanes add up to length minus start.
- R10: After reset `out_valid` is low, `req_ready` is high, every lane is idle and all starts and counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_vstart | input | IW = log2(VLEN)+1 | First active element index |
| req_vl | input | IW | Active vector length |
| req_ew | input | 2 | Element width code (0: 8-bit to 3: 64-bit) |
| out_valid | output | 1 | Per-lane results valid |
| out_ready | input | 1 | Consumer takes the results |
| out_start | output | LANES*LW | Per-lane local start, lane k at bits [k*LW +: LW], LW = IW-log2(LANES)+1 |
| out_count | output | LANES*LW | Per-lane element count, same packing |
| out_idle | output | LANES | Per-lane idle flag, bit k for lane k |

## Verification
The assertions take for granted that the request fields are stable and known whenever `req_valid` is high, and that `out_ready` is a known level every cycle. They make no assumption about legality: illegal requests (start at or past the length, length beyond the width's maximum, zero length) are expected to come out as all-idle results. The bench drives inputs only between clock edges, holds `req_valid` for exactly one accepted cycle, and picks lengths and starts within the index field width, on purpose including combinations that break the legality rule.

// File: rtl/vls_pkg.sv
package vls_pkg;

   typedef enum logic [1:0] {
      EW_8  = 2'd0,
      EW_16 = 2'd1,
      EW_32 = 2'd2,
      EW_64 = 2'd3
   } ew_e;

   // index field width: enough to hold VLEN itself (the largest legal length)
   function automatic int unsigned idx_width(int unsigned vlen);
      return $clog2(vlen) + 1;
   endfunction

   // per-lane field width, one spare bit above the largest per-lane end
   function automatic int unsigned lane_width(int unsigned vlen, int unsigned lanes);
      return $clog2(vlen) - $clog2(lanes) + 2;
   endfunction

endpackage

// File: rtl/vls_legal.sv
module vls_legal
   import vls_pkg::*;
#(
   parameter int unsigned VLEN = 2048,
   localparam int unsigned IW  = idx_width(VLEN)
) (
   input  logic [IW-1:0] vstart,
   input  logic [IW-1:0] vl,
   input  ew_e           ew,
   output logic          legal
);
   localparam logic [IW-1:0] MAXLEN = IW'(VLEN);

   logic [IW-1:0] limit;

   always_comb begin
      unique case (ew)
         EW_8:    limit = MAXLEN;
         EW_16:   limit = MAXLEN >> 1;
         EW_32:   limit = MAXLEN >> 2;
         default: limit = MAXLEN >> 3;
      endcase
   end

   assign legal = (vstart < vl) && (vl <= limit);

endmodule

// File: rtl/vls_lane_calc.sv
module vls_lane_calc
   import vls_pkg::*;
#(
   parameter int unsigned VLEN    = 2048,
   parameter int unsigned LANES   = 4,
   parameter int unsigned LANE_ID = 0,
   localparam int unsigned IW     = idx_width(VLEN),
   localparam int unsigned LW     = lane_width(VLEN, LANES),
   localparam int unsigned LG     = $clog2(LANES)
) (
   input  logic [IW-1:0] vstart,
   input  logic [IW-1:0] vl,
   input  logic          legal,
   output logic [LW-1:0] start,
   output logic [LW-1:0] count,
   output logic          idle
);
   localparam logic [LG-1:0] ID = LG'(LANE_ID);

   logic [LW-1:0] first_pos;
   logic [LW-1:0] end_pos;
   logic          skip_extra;
   logic          tail_extra;
   logic          has_work;

   // lanes below the start remainder already passed one more owned element
   assign skip_extra = ID < vstart[LG-1:0];
   // lanes below the length remainder own one more element before the end
   assign tail_extra = ID < vl[LG-1:0];

   assign first_pos = LW'(vstart >> LG) + LW'(skip_extra);
   assign end_pos   = LW'(vl >> LG)     + LW'(tail_extra);

   // compare before subtracting so the difference can never wrap
   assign has_work = legal && (end_pos > first_pos);

   assign count = has_work ? (end_pos - first_pos) : '0;
   assign start = has_work ? first_pos : '0;
   assign idle  = !has_work;

endmodule

// File: rtl/vls_out_stage.sv
module vls_out_stage #(
   parameter int unsigned LANES = 4,
   parameter int unsigned LW    = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                drain,
   input  logic [LANES*LW-1:0] d_start,
   input  logic [LANES*LW-1:0] d_count,
   input  logic [LANES-1:0]    d_idle,
   output logic                q_valid,
   output logic [LANES*LW-1:0] q_start,
   output logic [LANES*LW-1:0] q_count,
   output logic [LANES-1:0]    q_idle
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_start <= '0;
         q_count <= '0;
         q_idle  <= '1;
      end else if (load) begin
         q_valid <= 1'b1;
         q_start <= d_start;
         q_count <= d_count;
         q_idle  <= d_idle;
      end else if (q_valid && drain) begin
         q_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/vls_top.sv
module vls_top
   import vls_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned VLEN  = 2048,
   localparam int unsigned IW   = idx_width(VLEN),
   localparam int unsigned LW   = lane_width(VLEN, LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [IW-1:0]       req_vstart,
   input  logic [IW-1:0]       req_vl,
   input  logic [1:0]          req_ew,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [LANES*LW-1:0] out_start,
   output logic [LANES*LW-1:0] out_count,
   output logic [LANES-1:0]    out_idle
);

   generate
      if (!(LANES == 2 || LANES == 4 || LANES == 8 || LANES == 16)) begin : g_bad_lanes
         $error("vls_top: LANES must be 2, 4, 8 or 16");
      end
      if (VLEN < 64 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
         $error("vls_top: VLEN must be a power of two of at least 64");
      end
   endgenerate

   logic                legal;
   logic                take;
   logic [LANES*LW-1:0] nxt_start;
   logic [LANES*LW-1:0] nxt_count;
   logic [LANES-1:0]    nxt_idle;

   assign req_ready = !out_valid;
   assign take      = req_valid && req_ready;

   vls_legal #(.VLEN(VLEN)) u_legal (
      .vstart (req_vstart),
      .vl     (req_vl),
      .ew     (ew_e'(req_ew)),
      .legal  (legal)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      vls_lane_calc #(
         .VLEN    (VLEN),
         .LANES   (LANES),
         .LANE_ID (k)
      ) u_calc (
         .vstart (req_vstart),
         .vl     (req_vl),
         .legal  (legal),
         .start  (nxt_start[k*LW +: LW]),
         .count  (nxt_count[k*LW +: LW]),
         .idle   (nxt_idle[k])
      );
   end

   vls_out_stage #(.LANES(LANES), .LW(LW)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (take),
      .drain   (out_ready),
      .d_start (nxt_start),
      .d_count (nxt_count),
      .d_idle  (nxt_idle),
      .q_valid (out_valid),
      .q_start (out_start),
      .q_count (out_count),
      .q_idle  (out_idle)
   );

endmodule

// File: rtl/vls_checker.sv
module vls_checker
   import vls_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned VLEN  = 2048,
   localparam int unsigned IW   = idx_width(VLEN),
   localparam int unsigned LW   = lane_width(VLEN, LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_ready,
   input  logic [IW-1:0]       req_vstart,
   input  logic [IW-1:0]       req_vl,
   input  logic [1:0]          req_ew,
   input  logic                out_valid,
   input  logic                out_ready,
   input  logic [LANES*LW-1:0] out_start,
   input  logic [LANES*LW-1:0] out_count,
   input  logic [LANES-1:0]    out_idle
);
   localparam int unsigned SW   = IW + 5;
   localparam logic [LW-1:0] CAP = LW'(VLEN / LANES);

   logic          handshake;
   logic          fits;
   logic [SW-1:0] total;

   assign handshake = req_valid && req_ready;
   // width limit checked by scaling the length up instead of the limit down
   assign fits = (SW'(req_vl) << req_ew) <= SW'(VLEN);

   always_comb begin
      total = '0;
      for (int k = 0; k < LANES; k++) total = total + SW'(out_count[k*LW +: LW]);
   end

   p_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      handshake |=> out_valid);

   p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !req_ready);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_start)
                                     && $stable(out_count) && $stable(out_idle)));

   p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !req_valid) |=> !out_valid);

   p_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (handshake && (req_vstart < req_vl) && fits)
         |=> (total == SW'($past(req_vl)) - SW'($past(req_vstart))));

   p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (handshake && (req_vstart >= req_vl)) |=> (&out_idle) && (total == '0));

   p_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (handshake && !fits) |=> (&out_idle) && (total == '0));

   for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ((out_idle[k] == (out_count[k*LW +: LW] == '0))
                        && (!out_idle[k] || out_start[k*LW +: LW] == '0)));

      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ((out_count[k*LW +: LW] <= CAP)
                        && (out_start[k*LW +: LW] <= CAP)));
   end

endmodule

bind vls_top vls_checker #(.LANES(LANES), .VLEN(VLEN)) u_vls_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_vstart (req_vstart),
   .req_vl     (req_vl),
   .req_ew     (req_ew),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_start  (out_start),
   .out_count  (out_count),
   .out_idle   (out_idle)
);

// File: tb/sim_vls_top.sv
module sim_vls_top;
   localparam int LANES   = 4;
   localparam int VLEN    = 2048;
   localparam int IW      = $clog2(VLEN) + 1;
   localparam int LW      = $clog2(VLEN) - $clog2(LANES) + 2;
   localparam time TCLK   = 10ns;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic                req_ready;
   logic [IW-1:0]       req_vstart = '0;
   logic [IW-1:0]       req_vl = '0;
   logic [1:0]          req_ew = '0;
   logic                out_valid;
   logic                out_ready = 1'b0;
   logic [LANES*LW-1:0] out_start;
   logic [LANES*LW-1:0] out_count;
   logic [LANES-1:0]    out_idle;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #(TCLK/2) clk = ~clk;

   vls_top #(.LANES(LANES), .VLEN(VLEN)) u0 (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-clock handshake model
   bit mv = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) mv <= 0;
      else if (req_valid && !mv) mv <= 1;
      else if (mv && out_ready) mv <= 0;
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(out_valid == mv, "R7/R8 out_valid", int'(out_valid), int'(mv));
         chk(req_ready == !mv, "R7 req_ready", int'(req_ready), int'(!mv));
      end
   end

   // element-by-element reference
   int ref_s[LANES];
   int ref_c[LANES];

   task automatic reference(input int vs, input int vl, input int ew);
      int maxlen = VLEN >> ew;
      for (int k = 0; k < LANES; k++) begin
         ref_s[k] = 0;
         ref_c[k] = 0;
      end
      if (vs < vl && vl <= maxlen) begin
         for (int i = vs; i < vl; i++) begin
            if (ref_c[i % LANES] == 0) ref_s[i % LANES] = i / LANES;
            ref_c[i % LANES]++;
         end
      end
   endtask

   task automatic compare_lanes(input int vs, input int vl, input int ew);
      int sum = 0;
      reference(vs, vl, ew);
      for (int k = 0; k < LANES; k++) begin
         int as = int'(out_start[k*LW +: LW]);
         int ac = int'(out_count[k*LW +: LW]);
         sum += ac;
         chk(ac == ref_c[k], $sformatf("R1 count lane%0d vs=%0d vl=%0d ew=%0d", k, vs, vl, ew), ac, ref_c[k]);
         chk(as == ref_s[k], $sformatf("R2 start lane%0d vs=%0d vl=%0d ew=%0d", k, vs, vl, ew), as, ref_s[k]);
         chk(out_idle[k] == (ref_c[k] == 0), $sformatf("R6 idle lane%0d", k), int'(out_idle[k]), int'(ref_c[k] == 0));
         chk(ac <= VLEN / LANES, $sformatf("R3 bound lane%0d", k), ac, VLEN / LANES);
      end
      if (vs < vl && vl <= (VLEN >> ew))
         chk(sum == vl - vs, "R9 total", sum, vl - vs);
      else
         chk(sum == 0 && (&out_idle), "R4/R5 all idle", sum, 0);
   endtask

   task automatic send(input int vs, input int vl, input int ew, input int stall);
      logic [LANES*LW-1:0] hs;
      logic [LANES*LW-1:0] hc;
      @(negedge clk);
      req_vstart = IW'(vs);
      req_vl     = IW'(vl);
      req_ew     = 2'(ew);
      req_valid  = 1'b1;
      out_ready  = 1'b0;
      @(negedge clk);
      req_valid  = 1'b0;
      compare_lanes(vs, vl, ew);
      hs = out_start;
      hc = out_count;
      for (int t = 0; t < stall; t++) begin
         @(negedge clk);
         chk(out_start == hs && out_count == hc, "R8 hold", 0, 0);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
      chk(req_ready == 1'b1, "R10 req_ready", int'(req_ready), 1);
      chk(&out_idle, "R10 idle", int'(out_idle), (1 << LANES) - 1);
      chk(out_count == '0 && out_start == '0, "R10 fields", 0, 0);
      rst_n = 1'b1;

      send(1, 6, 0, 2);          // uneven split, lane 0 skips one
      send(2045, 2046, 0, 0);    // single element on lane 1
      send(0, 2048, 0, 1);       // full length
      send(2047, 2048, 0, 0);
      send(3, 3, 0, 0);          // R4 start equals length
      send(9, 4, 1, 0);          // R4 start past length
      send(0, 0, 0, 0);          // R4 zero length
      send(0, 300, 3, 0);        // R5 beyond 64-bit limit
      send(0, 256, 3, 0);        // R5 exactly at limit
      send(0, 1025, 1, 0);       // R5 one past 16-bit limit
      for (int a = 0; a < 2 * LANES; a++)
         for (int b = a + 1; b <= a + 2 * LANES; b++)
            send(a, b, 0, 0);
      for (int r = 0; r < 300; r++) begin
         int ew = $urandom_range(0, 3);
         int vl = $urandom_range(0, (VLEN >> ew) + 8);
         int vs = $urandom_range(0, vl + 2);
         send(vs, vl, ew, r % 3);
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule